// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around one accumulator. Data words are 16-bit two's-complement values. Main memory holds 4096 words and is addressed by word. Every instruction is one 16-bit word: the top four bits select the operation and the low twelve bits name a memory address. The core talks to a synchronous single-port memory over one address/data bus, reads bytes from an input port guarded by a valid flag, and sends bytes out through an output port with a one-cycle valid pulse.

Control is a hardwired state machine that performs one register transfer per clock. Every instruction starts with the same fetch sequence and then runs a fixed list of execute steps. The memory buffer feeds the accumulator and the adder directly, so those moves never occupy the memory bus. The indirect forms add one more memory read to fetch a pointer. A halt instruction, or any unassigned operation code, freezes the core until the next reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears every register, sets the program counter to 0 and holds halted, illegal_op, out_valid and mem_we low. The first fetch after reset reads address 0.
- R2: An instruction fetched in the cycle numbered t0 (the address phase) spends 5 cycles in fetch and decode, with its execute steps starting at t0+5. The total lengths are: JUMP, CLEAR, SKIPCOND and OUTPUT take 6 cycles; STORE takes 7; LOAD, ADD, SUBT, JUMPI and JNS take 8; ADDI takes 11. INPUT takes 2 cycles beyond its first execute cycle once data is accepted.
- R3: Opcode 1 (LOAD X) copies M[X] into the accumulator. Opcode 3 (ADD X) and opcode 4 (SUBT X) add or subtract M[X] with 16-bit wrap-around. Opcode A (CLEAR) sets the accumulator to 0.
- R4: Opcode 2 (STORE X) writes the accumulator to M[X]. The write is a single mem_we cycle at t0+6, with mem_addr equal to X.
- R5: Opcode B (ADDI X) reads a pointer P from the low 12 bits of M[X], then adds M[P] to the accumulator.
- R6: Opcode 9 (JUMP X) continues at X. Opcode C (JUMPI X) continues at the low 12 bits of M[X].
- R7: Opcode 0 (JNS X) writes the return address (the address after the JNS) to M[X] at t0+6 and continues at X+1.
- R8: Opcode 8 (SKIPCOND) skips the next instruction when the condition in bits 11..10 matches. The codes are: 00 for accumulator negative, 01 for accumulator zero, 10 for accumulator positive. Code 11 never matches.
- R9: Opcode 5 (INPUT) waits while in_valid is low. In the first execute cycle in which in_valid is high, it captures in_data, and it then loads the sign-extended byte into the accumulator.
- R10: Opcode 6 (OUTPUT) places the accumulator's low byte on out_data and raises out_valid for exactly one cycle, at t0+6.
- R11: Opcode 7 (HALT) and opcodes D to F stop the core from t0+5 on: halted is high, no memory write or output occurs, and the program counter holds. For opcodes D to F, illegal_op is also high from t0+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address (the address register) |
| mem_wdata | output | 16 | Memory write data (the buffer register) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_data | input | 8 | Input port byte |
| in_valid | input | 1 | Input byte is available |
| out_data | output | 8 | Output port byte |
| out_valid | output | 1 | One-cycle pulse marking a new output byte |
| halted | output | 1 | Core has stopped |
| illegal_op | output | 1 | Stop was caused by an unassigned opcode |

## Verification
A behavioural interpreter in the bench walks the program and computes the cycle at which every memory write, output pulse and stop is due. It counts from each instruction's fetch cycle t0: writes and output pulses fall at t0+6, a stop at t0+5, and an INPUT ends two cycles after the first execute cycle in which in_valid is high. The bench samples the ports at each falling edge after reset is released, with cycle 0 being the cycle in which reset drops, and compares them with the interpreter's expected values for that exact cycle. Any early, late, missing or spurious write or pulse is therefore a mismatch. Final memory words are also compared with values worked out by hand from the requirements.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_JNS   = 4'h0, OP_LOAD  = 4'h1, OP_STORE = 4'h2, OP_ADD   = 4'h3,
    OP_SUBT  = 4'h4, OP_INPUT = 4'h5, OP_OUTPUT= 4'h6, OP_HALT  = 4'h7,
    OP_SKIP  = 4'h8, OP_JUMP  = 4'h9, OP_CLEAR = 4'hA, OP_ADDI  = 4'hB,
    OP_JUMPI = 4'hC, OP_BAD_D = 4'hD, OP_BAD_E = 4'hE, OP_BAD_F = 4'hF
  } opcode_e;

  typedef enum logic [4:0] {
    S_FA, S_FW, S_FIR, S_FPC, S_DEC,
    S_RDW, S_MBR, S_IND, S_OPX,
    S_ST1, S_ST2, S_J1, S_J2, S_J3,
    S_JMP, S_CLR, S_SKP, S_INW, S_INA, S_OUT, S_HLT
  } state_e;

  typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IR, MAR_MBR} mar_sel_e;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_IR, PC_MBR, PC_MAR1} pc_sel_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_AC, MBR_PC} mbr_sel_e;
  typedef enum logic [2:0] {AC_HOLD, AC_MBR, AC_ADD, AC_SUB, AC_CLR, AC_IN} ac_sel_e;

  typedef struct packed {
    mar_sel_e mar;
    pc_sel_e  pc;
    mbr_sel_e mbr;
    ac_sel_e  ac;
    logic     ir_ld;
    logic     in_ld;
    logic     out_ld;
  } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] mbr,
  input  logic [1:0]        cond,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              skip_hit
);

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] sub_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic skip_match(input logic [DATA_W-1:0] v,
                                      input logic [1:0] code);
    logic neg, zero;
    neg  = v[DATA_W-1];
    zero = (v == '0);
    case (code)
      2'b00:   return neg;
      2'b01:   return zero;
      2'b10:   return !neg && !zero;
      default: return 1'b0;
    endcase
  endfunction

  assign sum      = add_wrap(ac, mbr);
  assign diff     = sub_wrap(ac, mbr);
  assign skip_hit = skip_match(ac, cond);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic         skip_hit,
  input  logic         in_valid,
  output ctrl_t        ctl,
  output logic         mem_we,
  output state_e       state,
  output logic         illegal
);

  state_e nxt;
  logic   ind_done;

  function automatic state_e dispatch(input logic [3:0] code);
    case (opcode_e'(code))
      OP_JNS:                                   return S_J1;
      OP_LOAD, OP_ADD, OP_SUBT, OP_ADDI, OP_JUMPI: return S_RDW;
      OP_STORE:                                 return S_ST1;
      OP_INPUT:                                 return S_INW;
      OP_OUTPUT:                                return S_OUT;
      OP_SKIP:                                  return S_SKP;
      OP_JUMP:                                  return S_JMP;
      OP_CLEAR:                                 return S_CLR;
      default:                                  return S_HLT;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FA;
      ind_done <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_FA)       ind_done <= 1'b0;
      else if (state == S_IND) ind_done <= 1'b1;
      if (state == S_DEC && op >= 4'hD) illegal <= 1'b1;
    end
  end

  always_comb begin
    nxt       = state;
    ctl.mar   = MAR_HOLD;
    ctl.pc    = PC_HOLD;
    ctl.mbr   = MBR_HOLD;
    ctl.ac    = AC_HOLD;
    ctl.ir_ld = 1'b0;
    ctl.in_ld = 1'b0;
    ctl.out_ld = 1'b0;
    mem_we    = 1'b0;
    case (state)
      S_FA:  begin ctl.mar = MAR_PC; nxt = S_FW; end
      S_FW:  nxt = S_FIR;
      S_FIR: begin ctl.ir_ld = 1'b1; nxt = S_FPC; end
      S_FPC: begin ctl.pc = PC_INC; nxt = S_DEC; end
      S_DEC: begin ctl.mar = MAR_IR; nxt = dispatch(op); end
      S_RDW: nxt = S_MBR;
      S_MBR: begin
        ctl.mbr = MBR_MEM;
        nxt = (opcode_e'(op) == OP_ADDI && !ind_done) ? S_IND : S_OPX;
      end
      S_IND: begin ctl.mar = MAR_MBR; nxt = S_RDW; end
      S_OPX: begin
        case (opcode_e'(op))
          OP_LOAD:          ctl.ac = AC_MBR;
          OP_ADD, OP_ADDI:  ctl.ac = AC_ADD;
          OP_SUBT:          ctl.ac = AC_SUB;
          OP_JUMPI:         ctl.pc = PC_MBR;
          default:          ;
        endcase
        nxt = S_FA;
      end
      S_ST1: begin ctl.mbr = MBR_AC; nxt = S_ST2; end
      S_ST2: begin mem_we = 1'b1; nxt = S_FA; end
      S_J1:  begin ctl.mbr = MBR_PC; nxt = S_J2; end
      S_J2:  begin mem_we = 1'b1; nxt = S_J3; end
      S_J3:  begin ctl.pc = PC_MAR1; nxt = S_FA; end
      S_JMP: begin ctl.pc = PC_IR; nxt = S_FA; end
      S_CLR: begin ctl.ac = AC_CLR; nxt = S_FA; end
      S_SKP: begin
        if (skip_hit) ctl.pc = PC_INC;
        nxt = S_FA;
      end
      S_INW: begin
        ctl.in_ld = in_valid;
        nxt = in_valid ? S_INA : S_INW;
      end
      S_INA: begin ctl.ac = AC_IN; nxt = S_FA; end
      S_OUT: begin ctl.out_ld = 1'b1; nxt = S_FA; end
      S_HLT: nxt = S_HLT;
      default: nxt = S_HLT;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  input  logic [DATA_W-1:0] alu_sum,
  input  logic [DATA_W-1:0] alu_diff,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [IO_W-1:0]   out_reg,
  output logic              out_v
);

  localparam int PAD_W = DATA_W - ADDR_W;
  localparam int EXT_W = DATA_W - IO_W;

  logic [IO_W-1:0] in_reg;

  function automatic logic [DATA_W-1:0] sext(input logic [IO_W-1:0] v);
    return {{EXT_W{v[IO_W-1]}}, v};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ac      <= '0;
      mbr     <= '0;
      ir      <= '0;
      pc      <= '0;
      mar     <= '0;
      in_reg  <= '0;
      out_reg <= '0;
      out_v   <= 1'b0;
    end else begin
      case (ctl.mar)
        MAR_PC:  mar <= pc;
        MAR_IR:  mar <= ir[ADDR_W-1:0];
        MAR_MBR: mar <= mbr[ADDR_W-1:0];
        default: ;
      endcase
      if (ctl.ir_ld) ir <= mem_rdata;
      case (ctl.pc)
        PC_INC:  pc <= pc + 1'b1;
        PC_IR:   pc <= ir[ADDR_W-1:0];
        PC_MBR:  pc <= mbr[ADDR_W-1:0];
        PC_MAR1: pc <= mar + 1'b1;
        default: ;
      endcase
      case (ctl.mbr)
        MBR_MEM: mbr <= mem_rdata;
        MBR_AC:  mbr <= ac;
        MBR_PC:  mbr <= {{PAD_W{1'b0}}, pc};
        default: ;
      endcase
      case (ctl.ac)
        AC_MBR:  ac <= mbr;
        AC_ADD:  ac <= alu_sum;
        AC_SUB:  ac <= alu_diff;
        AC_CLR:  ac <= '0;
        AC_IN:   ac <= sext(in_reg);
        default: ;
      endcase
      if (ctl.in_ld)  in_reg  <= in_data;
      if (ctl.out_ld) out_reg <= ac[IO_W-1:0];
      out_v <= ctl.out_ld;
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_valid,
  output logic [IO_W-1:0]   out_data,
  output logic              out_valid,
  output logic              halted,
  output logic              illegal_op
);

  localparam int OPC_W = DATA_W - ADDR_W;

  ctrl_t             ctl;
  state_e            state;
  logic [DATA_W-1:0] ac_q, mbr_q, ir_q, alu_sum, alu_diff;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [OPC_W-1:0]  op_field;
  logic              skip_hit;

  // named internal events for the checker
  logic ev_ir_load, ev_pc_step, ev_in_wait;

  assign op_field = ir_q[DATA_W-1 -: OPC_W];

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op       (op_field[3:0]),
    .skip_hit (skip_hit),
    .in_valid (in_valid),
    .ctl      (ctl),
    .mem_we   (mem_we),
    .state    (state),
    .illegal  (illegal_op)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .ac       (ac_q),
    .mbr      (mbr_q),
    .cond     (ir_q[ADDR_W-1 -: 2]),
    .sum      (alu_sum),
    .diff     (alu_diff),
    .skip_hit (skip_hit)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_W(IO_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .in_data   (in_data),
    .alu_sum   (alu_sum),
    .alu_diff  (alu_diff),
    .ac        (ac_q),
    .mbr       (mbr_q),
    .ir        (ir_q),
    .pc        (pc_q),
    .mar       (mar_q),
    .out_reg   (out_data),
    .out_v     (out_valid)
  );

  assign mem_addr   = mar_q;
  assign mem_wdata  = mbr_q;
  assign halted     = (state == S_HLT);
  assign ev_ir_load = ctl.ir_ld;
  assign ev_pc_step = (ctl.pc == PC_INC);
  assign ev_in_wait = (state == S_INW);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] ir_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic              out_valid,
  input logic              halted,
  input logic              illegal_op,
  input logic              in_valid,
  input logic              ev_ir_load,
  input logic              ev_pc_step,
  input logic              ev_in_wait
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!halted && !out_valid && !mem_we && !illegal_op));

  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
    ev_ir_load |=> ev_pc_step);

  // covers both STORE (R4) and JNS (R7) writes
  assert_write_addr_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == ir_q[ADDR_W-1:0]));

  assert_input_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_in_wait && !in_valid) |=> ev_in_wait);

  assert_out_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_q) && !mem_we));

  assert_illegal_halts_R11: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> halted);

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .ir_q       (ir_q),
  .pc_q       (pc_q),
  .out_valid  (out_valid),
  .halted     (halted),
  .illegal_op (illegal_op),
  .in_valid   (in_valid),
  .ev_ir_load (ev_ir_load),
  .ev_pc_step (ev_pc_step),
  .ev_in_wait (ev_in_wait)
);

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
module acc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, in_valid, out_valid, halted, illegal_op;
  logic [7:0]  in_data, out_data;

  always #2.5 clk = ~clk;

  acc_core dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid),
    .halted(halted), .illegal_op(illegal_op)
  );

  // bench memory and loader
  logic [15:0] mem [4096];
  logic        clr_all = 1'b0, ld_en = 1'b0;
  logic [11:0] ld_a = '0;
  logic [15:0] ld_d = '0;

  always @(posedge clk) begin
    if (clr_all) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
    end else if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we)    mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int cyc = 0;
  int vf = 0;
  logic [7:0] in_byte = '0;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;
  assign in_valid = !rst && (cyc >= vf);
  assign in_data  = in_byte;

  // reference model state
  logic [15:0] mm [4096];
  logic        e_we [1024];
  logic [11:0] e_wa [1024];
  logic [15:0] e_wd [1024];
  string       e_tag [1024];
  logic        e_ov [1024];
  logic [7:0]  e_od [1024];
  int          halt_c;
  logic        ill_e;

  int checks = 0, fails = 0;
  logic wd_hit = 1'b0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    mm[a] = d;
    @(negedge clk); ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic begin_scenario();
    @(negedge clk); rst = 1'b1; clr_all = 1'b1;
    @(negedge clk); clr_all = 1'b0;
    for (int i = 0; i < 4096; i++) mm[i] = '0;
    for (int i = 0; i < 1024; i++) begin
      e_we[i] = 1'b0; e_wa[i] = '0; e_wd[i] = '0; e_tag[i] = "R2";
      e_ov[i] = 1'b0; e_od[i] = '0;
    end
    @(negedge clk);
    chk(!halted && !out_valid && !mem_we && !illegal_op, "R1", "reset outputs",
        {28'd0, halted, out_valid, mem_we, illegal_op}, 32'd0);
  endtask

  // behavioural interpreter with per-instruction cycle lengths
  task automatic run_model();
    logic [11:0] pc, x, p;
    logic [15:0] ac, ir;
    int t, t0, c;
    logic hit;
    pc = 0; ac = 0; t = 0;
    forever begin
      t0 = t; ir = mm[pc]; pc = pc + 1;
      x = ir[11:0];
      case (ir[15:12])
        4'h0: begin mm[x] = {4'h0, pc};
                e_we[t0+6] = 1; e_wa[t0+6] = x; e_wd[t0+6] = {4'h0, pc}; e_tag[t0+6] = "R7";
                pc = x + 1; t = t0 + 8; end
        4'h1: begin ac = mm[x]; t = t0 + 8; end
        4'h2: begin mm[x] = ac;
                e_we[t0+6] = 1; e_wa[t0+6] = x; e_wd[t0+6] = ac; e_tag[t0+6] = "R4";
                t = t0 + 7; end
        4'h3: begin ac = ac + mm[x]; t = t0 + 8; end
        4'h4: begin ac = ac - mm[x]; t = t0 + 8; end
        4'h5: begin c = (t0 + 5 > vf) ? t0 + 5 : vf;
                ac = {{8{in_byte[7]}}, in_byte}; t = c + 2; end
        4'h6: begin e_ov[t0+6] = 1; e_od[t0+6] = ac[7:0]; t = t0 + 6; end
        4'h8: begin
                case (ir[11:10])
                  2'b00: hit = ($signed(ac) < 0);
                  2'b01: hit = (ac == 0);
                  2'b10: hit = ($signed(ac) > 0);
                  default: hit = 0;
                endcase
                if (hit) pc = pc + 1;
                t = t0 + 6; end
        4'h9: begin pc = x; t = t0 + 6; end
        4'hA: begin ac = 0; t = t0 + 6; end
        4'hB: begin p = mm[x][11:0]; ac = ac + mm[p]; t = t0 + 11; end
        4'hC: begin pc = mm[x][11:0]; t = t0 + 8; end
        default: begin halt_c = t0 + 5; ill_e = (ir[15:12] >= 4'hD); return; end
      endcase
    end
  endtask

  task automatic run_and_compare();
    run_model();
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < halt_c + 20 && c < 1024; c++) begin
      chk(mem_we == e_we[c], e_we[c] ? e_tag[c] : "R2", $sformatf("mem_we cycle %0d", c),
          {31'd0, mem_we}, {31'd0, e_we[c]});
      if (mem_we && e_we[c])
        chk({mem_addr, mem_wdata} == {e_wa[c], e_wd[c]}, e_tag[c],
            $sformatf("write addr/data cycle %0d", c),
            {4'd0, mem_addr, mem_wdata}, {4'd0, e_wa[c], e_wd[c]});
      chk(out_valid == e_ov[c], e_ov[c] ? "R10" : "R8", $sformatf("out_valid cycle %0d", c),
          {31'd0, out_valid}, {31'd0, e_ov[c]});
      if (out_valid && e_ov[c])
        chk(out_data == e_od[c], "R10", $sformatf("out_data cycle %0d", c),
            {24'd0, out_data}, {24'd0, e_od[c]});
      chk(halted == (c >= halt_c), "R6 R8 R11", $sformatf("halted cycle %0d", c),
          {31'd0, halted}, {31'd0, (c >= halt_c)});
      chk(illegal_op == (ill_e && c >= halt_c), "R11", $sformatf("illegal_op cycle %0d", c),
          {31'd0, illegal_op}, {31'd0, (ill_e && c >= halt_c)});
      @(negedge clk);
    end
  endtask

  task automatic run_all();
    // scenario 1: full instruction mix, input arrives late, illegal stop
    begin_scenario();
    vf = 200; in_byte = 8'h9C;
    put(12'h000, 16'h1100); put(12'h001, 16'h3101); put(12'h002, 16'h2102);
    put(12'h003, 16'h4103); put(12'h004, 16'h2104); put(12'h005, 16'h6000);
    put(12'h006, 16'hB105); put(12'h007, 16'h2106); put(12'h008, 16'h8400);
    put(12'h009, 16'h6000); put(12'h00A, 16'hA000); put(12'h00B, 16'h8400);
    put(12'h00C, 16'h6000); put(12'h00D, 16'h0200); put(12'h00E, 16'h9010);
    put(12'h00F, 16'h6000); put(12'h010, 16'h8000); put(12'h011, 16'h7000);
    put(12'h012, 16'h8800); put(12'h013, 16'hD000);
    put(12'h201, 16'h5000); put(12'h202, 16'h2107); put(12'h203, 16'h6000);
    put(12'h204, 16'hC200);
    put(12'h100, 16'h1234); put(12'h101, 16'h0F0F); put(12'h103, 16'h2000);
    put(12'h105, 16'h0101);
    run_and_compare();
    chk(mem[12'h102] == 16'h2143, "R3", "sum stored", {16'd0, mem[12'h102]}, 32'h2143);
    chk(mem[12'h104] == 16'h0143, "R3", "difference stored", {16'd0, mem[12'h104]}, 32'h0143);
    chk(mem[12'h106] == 16'h1052, "R5", "indirect sum stored", {16'd0, mem[12'h106]}, 32'h1052);
    chk(mem[12'h200] == 16'h000E, "R7", "return address", {16'd0, mem[12'h200]}, 32'h000E);
    chk(mem[12'h107] == 16'hFF9C, "R9", "sign-extended input", {16'd0, mem[12'h107]}, 32'hFF9C);
    chk(halted && illegal_op, "R11", "illegal stop held", {30'd0, halted, illegal_op}, 32'd3);

    // scenario 2: ready input, positive skip, overflow wrap, plain halt
    begin_scenario();
    vf = 0; in_byte = 8'h05;
    put(12'h000, 16'h5000); put(12'h001, 16'h8800); put(12'h002, 16'h7000);
    put(12'h003, 16'h6000); put(12'h004, 16'h1020); put(12'h005, 16'h3021);
    put(12'h006, 16'h2022); put(12'h007, 16'h7000);
    put(12'h020, 16'h7FFF); put(12'h021, 16'h0001);
    run_and_compare();
    chk(mem[12'h022] == 16'h8000, "R3", "wrapped sum", {16'd0, mem[12'h022]}, 32'h8000);
    chk(halted && !illegal_op, "R11", "plain halt", {30'd0, halted, illegal_op}, 32'd2);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd_hit = 1'b1; end
    join_any
    if (wd_hit) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule